// File: doc/BRIEF.md
# Conversion Result Queue with Threshold Request

This block sits between an analog-to-digital conversion engine and the bus fabric and holds conversion results in a small first-in first-out queue. Each sample-valid strobe from the engine writes a 12-bit result, and with it the conversion error bit if software has turned that option on. Software or a DMA engine takes results one at a time with a pop strobe. The entry at the head of the queue is always visible on the read-data port.

A single control/status word gives the number of waiting entries, full and empty indications, and two sticky fault flags: one for a write that arrived while the queue was full and one for a pop that found it empty. A fault flag is cleared only by writing 1 to its bit. The same word also holds a programmable fill threshold, a DMA-request enable and the error-inclusion option. An interrupt request is raised while the fill level is at or above the threshold. The DMA request follows the same comparison but only when the DMA enable is set.

Top module: `adc_sample_fifo`

## Requirements
- R1: After reset the status word reads 0x0010: level 0, empty (bit 4) set, full (bit 5) clear, both fault flags clear, threshold 0, DMA enable and error inclusion off.
- R2: Results leave in the order they were written. `popData[11:0]` shows the oldest entry, a pop removes it, and the level (status bits 3:0) counts the waiting entries.
- R3: A sample written while the queue is full is discarded, the entries already stored are kept, and the overflow flag (status bit 6) is set.
- R4: A pop while the queue is empty sets the underflow flag (status bit 7), reads `popData` as zero and leaves the level at 0.
- R5: Both fault flags stay set until a configuration write has a 1 in the flag's own bit (6 or 7). Writing 0 there changes nothing. When a new fault and a clear fall in the same cycle, the flag stays set.
- R6: A push and a pop in the same cycle on a queue that is neither empty nor full leave the level unchanged and keep the order of the entries.
- R7: `irqReq` is 1 exactly when the level is greater than or equal to the 4-bit threshold held in configuration bits 11:8.
- R8: `dmaReq` is 1 only when the DMA enable (bit 12) is 1 and the level is at or above the threshold.
- R9: With error inclusion (bit 13) set when a sample is written, its error bit is stored and read back at `popData[15]`. With the option clear it reads 0. `popData[14:12]` always reads 0.
- R10: Full is set when the level equals the queue depth (8) and empty when it is 0. Writes to bits 5:0 of the configuration word have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sampleValid | input | 1 | A conversion result is presented this cycle |
| sampleData | input | 12 | Conversion result |
| sampleErr | input | 1 | Conversion error bit for this result |
| popReq | input | 1 | Remove the head entry at this clock edge |
| popData | output | 16 | Head entry: error at bit 15, result at bits 11:0 |
| cfgWe | input | 1 | Configuration write strobe |
| cfgWdata | input | 16 | Configuration write data (same layout as the status word) |
| statusWord | output | 16 | Level, empty, full, fault flags, threshold, enables |
| irqReq | output | 1 | Interrupt request, level at or above threshold |
| dmaReq | output | 1 | DMA request, gated by the DMA enable |

## Verification
Two kinds of event can land on the same clock edge. The first is a sample write together with a pop: the bench drives both strobes in one cycle on a partly filled queue, then checks that the level has not moved and that the scoreboard's order still matches. The second is a fault together with a write-1 clear of the same flag: the bench fills the queue, then in one cycle drives a further sample and a configuration write with bit 6 set. It expects the overflow flag to stay set after that cycle and to clear only after a later clear that comes with no fault.

// File: rtl/adc_fifo_pkg.sv
package adc_fifo_pkg;
  localparam int RESULT_W = 12;
  localparam int WORD_W   = 16;
  localparam int LVL_W    = 4;

  localparam int EMPTY_BIT = 4;
  localparam int FULL_BIT  = 5;
  localparam int OVER_BIT  = 6;
  localparam int UNDER_BIT = 7;
  localparam int THR_LO    = 8;
  localparam int DMA_BIT   = 12;
  localparam int ERRI_BIT  = 13;

  typedef struct packed {
    logic                err;
    logic [RESULT_W-1:0] result;
  } fifoEntry_t;

  typedef struct packed {
    logic push;
    logic pop;
  } fifoStrobe_t;
endpackage

// File: rtl/adc_fifo_datapath.sv
module adc_fifo_datapath
  import adc_fifo_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoStrobe_t      strobe,
  input  fifoEntry_t       pushEntry,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty,
  output fifoEntry_t       headEntry
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [LVL_W-1:0] DEPTH_LVL = LVL_W'(DEPTH);

  fifoEntry_t       store [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  assign full  = (level == DEPTH_LVL);
  assign empty = (level == '0);
  assign headEntry = empty ? '0 : store[rdPtr];

  always_ff @(posedge clk) begin
    if (strobe.push) store[wrPtr] <= pushEntry;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (strobe.push) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (strobe.pop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({strobe.push, strobe.pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  a_r10_full_empty_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(full && empty));
  a_r6_level_hold: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.push && strobe.pop) |=> $stable(level));
  a_r3_no_push_when_full: assert property (@(posedge clk) disable iff (!rstN)
    full |-> !strobe.push);
  a_r4_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rstN)
    empty |-> !strobe.pop);
endmodule

// File: rtl/adc_fifo_ctrl.sv
module adc_fifo_ctrl
  import adc_fifo_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic              sampleErr,
  input  logic              popReq,
  input  logic              cfgWe,
  input  logic [WORD_W-1:0] cfgWdata,
  input  logic [LVL_W-1:0]  level,
  input  logic              full,
  input  logic              empty,
  output fifoStrobe_t       strobe,
  output logic              pushErr,
  output logic [WORD_W-1:0] statusWord,
  output logic              irqReq,
  output logic              dmaReq
);
  logic [LVL_W-1:0] threshold;
  logic             dmaEnable;
  logic             errInclude;
  logic             overFlag;
  logic             underFlag;
  logic             overSet;
  logic             underSet;
  logic             overClr;
  logic             underClr;
  logic             atThreshold;

  assign strobe.push = sampleValid && !full;
  assign strobe.pop  = popReq && !empty;
  assign pushErr     = sampleErr && errInclude;

  assign overSet  = sampleValid && full;
  assign underSet = popReq && empty;
  assign overClr  = cfgWe && cfgWdata[OVER_BIT];
  assign underClr = cfgWe && cfgWdata[UNDER_BIT];

  assign atThreshold = (level >= threshold);
  assign irqReq = atThreshold;
  assign dmaReq = atThreshold && dmaEnable;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      threshold  <= '0;
      dmaEnable  <= 1'b0;
      errInclude <= 1'b0;
      overFlag   <= 1'b0;
      underFlag  <= 1'b0;
    end else begin
      if (cfgWe) begin
        threshold  <= cfgWdata[THR_LO +: LVL_W];
        dmaEnable  <= cfgWdata[DMA_BIT];
        errInclude <= cfgWdata[ERRI_BIT];
      end
      if (overSet)       overFlag <= 1'b1;
      else if (overClr)  overFlag <= 1'b0;
      if (underSet)      underFlag <= 1'b1;
      else if (underClr) underFlag <= 1'b0;
    end
  end

  always_comb begin
    statusWord = '0;
    statusWord[LVL_W-1:0]        = level;
    statusWord[EMPTY_BIT]        = empty;
    statusWord[FULL_BIT]         = full;
    statusWord[OVER_BIT]         = overFlag;
    statusWord[UNDER_BIT]        = underFlag;
    statusWord[THR_LO +: LVL_W]  = threshold;
    statusWord[DMA_BIT]          = dmaEnable;
    statusWord[ERRI_BIT]         = errInclude;
  end

  a_r5_over_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (overFlag && !overClr) |=> overFlag);
  a_r5_under_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (underFlag && !underClr) |=> underFlag);
  a_r3_over_sets: assert property (@(posedge clk) disable iff (!rstN)
    overSet |=> overFlag);
  a_r8_dma_gated: assert property (@(posedge clk) disable iff (!rstN)
    !dmaEnable |-> !dmaReq);
  a_r7_irq_follows_level: assert property (@(posedge clk) disable iff (!rstN)
    (level == '0 && threshold != '0) |-> !irqReq);
endmodule

// File: rtl/adc_sample_fifo.sv
module adc_sample_fifo
  import adc_fifo_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [RESULT_W-1:0] sampleData,
  input  logic                sampleErr,
  input  logic                popReq,
  output logic [WORD_W-1:0]   popData,
  input  logic                cfgWe,
  input  logic [WORD_W-1:0]   cfgWdata,
  output logic [WORD_W-1:0]   statusWord,
  output logic                irqReq,
  output logic                dmaReq
);
  localparam int PAD_W = WORD_W - RESULT_W - 1;

  fifoStrobe_t      strobe;
  fifoEntry_t       pushEntry;
  fifoEntry_t       headEntry;
  logic             pushErr;
  logic [LVL_W-1:0] level;
  logic             full;
  logic             empty;

  assign pushEntry.result = sampleData;
  assign pushEntry.err    = pushErr;
  assign popData = {headEntry.err, {PAD_W{1'b0}}, headEntry.result};

  adc_fifo_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleErr(sampleErr),
    .popReq(popReq), .cfgWe(cfgWe), .cfgWdata(cfgWdata), .level(level),
    .full(full), .empty(empty), .strobe(strobe), .pushErr(pushErr),
    .statusWord(statusWord), .irqReq(irqReq), .dmaReq(dmaReq)
  );

  adc_fifo_datapath #(.DEPTH(DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pushEntry(pushEntry),
    .level(level), .full(full), .empty(empty), .headEntry(headEntry)
  );
endmodule

// File: tb/tb_adc_sample_fifo.sv
module tb_adc_sample_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [11:0] sampleData = '0;
  logic        sampleErr = 1'b0;
  logic        popReq = 1'b0;
  logic [15:0] popData;
  logic        cfgWe = 1'b0;
  logic [15:0] cfgWdata = '0;
  logic [15:0] statusWord;
  logic        irqReq;
  logic        dmaReq;

  int errors = 0;
  int checks = 0;
  logic [15:0] expQ[$];
  logic        errInclModel = 1'b0;
  logic        summaryDone = 1'b0;

  adc_sample_fifo #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleData(sampleData),
    .sampleErr(sampleErr), .popReq(popReq), .popData(popData), .cfgWe(cfgWe),
    .cfgWdata(cfgWdata), .statusWord(statusWord), .irqReq(irqReq), .dmaReq(dmaReq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: compares the head shown during every pop against the scoreboard.
  always @(negedge clk) begin
    if (rstN && popReq) begin
      if (expQ.size() == 0) chk("R4 pop on empty reads zero", popData, 16'h0);
      else chk("R2 R9 popped entry", popData, expQ.pop_front());
    end
  end

  // Driver: one cycle with the given strobes; records expected pushes.
  task automatic step(input logic doPush, input logic [11:0] d, input logic e,
                      input logic doPop, input logic doCfg, input logic [15:0] w);
    sampleValid = doPush; sampleData = d; sampleErr = e;
    popReq = doPop; cfgWe = doCfg; cfgWdata = w;
    if (doPush && expQ.size() < DEPTH)
      expQ.push_back({e & errInclModel, 3'b000, d});
    @(posedge clk);
    #1;
    if (doCfg) errInclModel = w[13];
    sampleValid = 0; popReq = 0; cfgWe = 0; cfgWdata = '0; sampleErr = 0;
  endtask

  task automatic pushS(input logic [11:0] d, input logic e);
    step(1, d, e, 0, 0, '0);
  endtask
  task automatic popS();
    step(0, '0, 0, 1, 0, '0);
  endtask
  task automatic cfgS(input logic [15:0] w);
    step(0, '0, 0, 0, 1, w);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!summaryDone) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
    #1;
    chk("R1 reset status", statusWord, 16'h0010);
    chk("R7 irq at reset with threshold 0", irqReq, 1);
    chk("R8 dma off at reset", dmaReq, 0);
    chk("R4 R1 empty head reads zero", popData, 16'h0);

    // threshold 3, DMA on
    cfgS(16'h1300);
    pushS(12'h101, 1); pushS(12'h202, 0);
    chk("R7 irq below threshold", irqReq, 0);
    chk("R8 dma below threshold", dmaReq, 0);
    pushS(12'h303, 0);
    chk("R7 irq at threshold", irqReq, 1);
    chk("R8 dma at threshold", dmaReq, 1);
    chk("R2 level three", statusWord[3:0], 3);
    chk("R9 err not stored when inclusion off", popData, 16'h0101);
    popS(); popS();
    chk("R2 level after pops", statusWord[3:0], 1);

    // simultaneous push and pop
    step(1, 12'h404, 0, 1, 0, '0);
    chk("R6 level unchanged", statusWord[3:0], 1);
    step(1, 12'h505, 0, 1, 0, '0);
    chk("R6 head after concurrent ops", popData, 16'h0505);

    // fill to full, then overflow
    for (int i = 0; i < 7; i++) pushS(12'h600 + 12'(i), 0);
    chk("R10 full set", statusWord[5:0], 6'h28);
    pushS(12'hBAD, 0);
    chk("R3 overflow set, level kept", statusWord[7:0], 8'h68);
    cfgS(16'h1300);
    chk("R5 writing 0 keeps overflow", statusWord[6], 1);
    step(1, 12'hBAE, 0, 0, 1, 16'h1340);
    chk("R5 set wins over clear", statusWord[6], 1);
    cfgS(16'h1340);
    chk("R5 overflow cleared by write 1", statusWord[6], 0);
    for (int i = 0; i < DEPTH; i++) popS();
    chk("R3 R2 drained to empty", statusWord[5:0], 6'h10);

    // underflow
    popS();
    chk("R4 underflow set", statusWord[7], 1);
    chk("R4 level stays 0", statusWord[3:0], 0);
    cfgS(16'h0000);
    chk("R5 underflow stays after write 0", statusWord[7], 1);
    cfgS(16'h0080);
    chk("R5 underflow cleared", statusWord[7], 0);

    // error inclusion, DMA disabled at threshold 1
    cfgS(16'h2100);
    pushS(12'hA5A, 1);
    chk("R9 err at bit 15", popData, 16'h8A5A);
    chk("R8 dma gated off", dmaReq, 0);
    chk("R7 irq on at level 1", irqReq, 1);
    cfgS(16'h0100);
    pushS(12'hFFF, 1);
    popS(); popS();
    chk("R10 writes to low bits ignored", statusWord, 16'h0110);
    cfgS(16'h003F);
    chk("R10 RO bits unchanged after write", statusWord[5:0], 6'h10);

    summaryDone = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule